// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits next to a small 8-bit CPU core and decides which of five event sources the core should service next. The five sources are two external request pins, two timer-overflow events and one serial event. The serial event counts when either its receive flag or its transmit flag is raised. Each external or timer source latches a pending flag. A pending source becomes a request when its own enable bit and the global enable bit are both set. The arbiter then picks one request using a per-source priority bit and a fixed order within each level.

The CPU sees one request line and a 16-bit vector address. The vector addresses start at 0x0003 and are spaced eight bytes apart. The CPU signals that it has taken the vector by pulsing an acknowledge input. The block then records the level it has entered and clears the flag of the source it served, where that flag is one the block owns. A return pulse ends the innermost active level. This allows a high-priority request to interrupt a low-priority handler, but not the reverse.

Each external pin can be set for falling-edge or low-level triggering. The enable and priority bits are driven from registers held by the CPU. Software can also clear the latched external and timer flags through a clear strobe.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Source index order is ext0=0, timer0=1, ext1=2, timer1=3, serial=4. The vector for index i is 0x0003 + 8*i, so ext0→0x0003, timer0→0x000B, ext1→0x0013, timer1→0x001B and serial→0x0023.
- R2: When `irq_glob_en` is 0, `irq_req` stays 0 whatever flags and individual enables are set.
- R3: A pending source is a request only when bit i of `irq_src_en` is 1 and `irq_glob_en` is 1.
- R4: When requests exist at both levels, a source with its `irq_pri` bit at 1 (high) is chosen over any source with the bit at 0 (low).
- R5: Among requests of the same level, the lowest source index wins.
- R6: While a low-level handler is active, only high-level requests raise `irq_req`. While a high-level handler is active, no request raises `irq_req`. An accepted acknowledge marks the chosen source's level as active from the next cycle.
- R7: Each `irq_ret` pulse ends the high level if it is active, and otherwise ends the low level.
- R8: An external pin in edge mode (`ext_edge_sel`=1) sets its flag two clock edges after a falling transition on the pin. The flag stays set after the pin rises again. It is cleared by an acknowledge of that source or by its `flag_clr` bit.
- R9: An external pin in level mode (`ext_edge_sel`=0) shows a pending flag that follows the inverted pin with a two-edge lag. An acknowledge does not clear it.
- R10: An accepted acknowledge clears the flag of the chosen edge-mode external source or timer source only. Other flags are untouched.
- R11: The serial pending flag (`pend[4]`) equals `ser_rx | ser_tx` in the same cycle. The block never clears it.
- R12: After reset, no flag is set and no level is active.
- R13: An `irq_ack` pulse while `irq_req` is 0 changes no flag and no active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin_n | input | 2 | External request pins, active low |
| ext_edge_sel | input | 2 | Per pin: 1 = falling-edge trigger, 0 = low-level trigger |
| tmr_ovf | input | 2 | One-cycle timer overflow events |
| ser_rx | input | 1 | Serial receive flag, held by the UART |
| ser_tx | input | 1 | Serial transmit flag, held by the UART |
| irq_glob_en | input | 1 | Global enable |
| irq_src_en | input | 5 | Per-source enables, indexed as in R1 |
| irq_pri | input | 5 | Per-source level, 1 = high |
| flag_clr | input | 4 | Software clear of latched flags for indices 0..3 |
| irq_ack | input | 1 | CPU has taken the current vector |
| irq_ret | input | 1 | Return-from-handler pulse |
| irq_req | output | 1 | Request to vector now |
| irq_vec | output | 16 | Vector address of the chosen source |
| pend | output | 5 | Pending flags, indexed as in R1 |

## Verification
The bench sets every combination of pending sources against every priority mask and every enable mask. A design with a wrong winner order or a reversed priority would point the CPU at the wrong vector in one of these cases. Nesting is tested step by step. A design that let a low request preempt a low handler would raise a request that should stay silent. So would a design that cleared both levels, or the low level first, on a return pulse. The bench also checks the case a careless design gets wrong most easily: an acknowledge while no request is raised. Such a design would clear a flag or enter a level. The bench also confirms that level-mode and serial flags survive an acknowledge, and that the edge flag keeps its two-edge timing.

// File: rtl/vec_irq_pkg.sv
// Shared constants and helpers for the vectored interrupt controller.
// Assumes sources interleave external and timer inputs, then serial last.
package vec_irq_pkg;
    localparam int NUM_EXT    = 2;
    localparam int NUM_TMR    = 2;
    localparam int NUM_LATCH  = NUM_EXT + NUM_TMR;
    localparam int NUM_SRC    = NUM_LATCH + 1;
    localparam int SER_IDX    = NUM_LATCH;
    localparam int IDX_W      = $clog2(NUM_SRC);
    localparam int VEC_W      = 16;
    localparam int VEC_BASE   = 3;
    localparam int VEC_STRIDE = 8;

    // Vector address for a source index.
    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        return VEC_W'(VEC_BASE) + VEC_W'(idx) * VEC_W'(VEC_STRIDE);
    endfunction
endpackage

// File: rtl/irq_pin_src.sv
// Flag latch for one active-low external request pin.
// Edge mode: sets on a sampled falling edge, held until clr.
// Level mode: follows the inverted sampled pin, clr has no effect.
// Assumes pin_n is synchronous to clk or already synchronised.
module irq_pin_src (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic flag
);
    logic pin_q;
    logic pin_qq;
    logic fall;

    assign fall = pin_qq & ~pin_q;

    // Sample the pin twice to find a falling transition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q  <= 1'b1;
            pin_qq <= 1'b1;
        end else begin
            pin_q  <= pin_n;
            pin_qq <= pin_q;
        end
    end

    // Update the pending flag according to the trigger mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (edge_mode) begin
            flag <= fall | (flag & ~clr);
        end else begin
            flag <= ~pin_q;
        end
    end
endmodule

// File: rtl/irq_evt_src.sv
// Flag latch for a one-cycle event such as a timer overflow.
// A new event in the same cycle as clr wins, so no event is lost.
module irq_evt_src (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic flag
);
    // Set on event, hold, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= evt | (flag & ~clr);
    end
endmodule

// File: rtl/irq_pick.sv
// Combinational arbiter: high-level requests beat low-level ones, and the
// lowest index wins within a level. Reports the winner and its level.
module irq_pick
    import vec_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_SRC-1:0] pri,
    output logic               valid,
    output logic [IDX_W-1:0]   idx,
    output logic               lvl_hi
);
    logic             hi_any;
    logic             lo_any;
    logic [IDX_W-1:0] hi_idx;
    logic [IDX_W-1:0] lo_idx;

    // Scan downward so that the lowest requesting index remains.
    always_comb begin
        hi_any = 1'b0;
        lo_any = 1'b0;
        hi_idx = '0;
        lo_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i] && pri[i]) begin
                hi_any = 1'b1;
                hi_idx = IDX_W'(i);
            end
            if (req[i] && !pri[i]) begin
                lo_any = 1'b1;
                lo_idx = IDX_W'(i);
            end
        end
    end

    // Select the winning level.
    always_comb begin
        valid  = hi_any | lo_any;
        lvl_hi = hi_any;
        idx    = hi_any ? hi_idx : lo_idx;
    end
endmodule

// File: rtl/irq_isv.sv
// Two in-service bits. set_* enters a level, and ret leaves the highest
// active level. Assumes set_hi and set_lo are never both high.
module irq_isv (
    input  logic clk,
    input  logic rst_n,
    input  logic set_hi,
    input  logic set_lo,
    input  logic ret,
    output logic isv_hi,
    output logic isv_lo
);
    // Track the active service levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isv_hi <= 1'b0;
            isv_lo <= 1'b0;
        end else begin
            isv_hi <= (isv_hi & ~ret) | set_hi;
            isv_lo <= (isv_lo & ~(ret & ~isv_hi)) | set_lo;
        end
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
// Two-level vectored interrupt controller, top level.
// Latches the external and timer flags and derives the serial flag.
// Gates requests with the enables, arbitrates, and blocks requests the
// active levels do not allow. Enters and leaves levels on ack and ret.
// Assumes the CPU pulses irq_ack only for one cycle while irq_req is high.
module vec_irq_ctrl
    import vec_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_EXT-1:0]   ext_pin_n,
    input  logic [NUM_EXT-1:0]   ext_edge_sel,
    input  logic [NUM_TMR-1:0]   tmr_ovf,
    input  logic                 ser_rx,
    input  logic                 ser_tx,
    input  logic                 irq_glob_en,
    input  logic [NUM_SRC-1:0]   irq_src_en,
    input  logic [NUM_SRC-1:0]   irq_pri,
    input  logic [NUM_LATCH-1:0] flag_clr,
    input  logic                 irq_ack,
    input  logic                 irq_ret,
    output logic                 irq_req,
    output logic [VEC_W-1:0]     irq_vec,
    output logic [NUM_SRC-1:0]   pend
);
    logic [NUM_SRC-1:0]   req;
    logic [NUM_LATCH-1:0] take_src;
    logic                 sel_valid;
    logic [IDX_W-1:0]     sel_idx;
    logic                 sel_hi;
    logic                 take;
    logic                 isv_hi;
    logic                 isv_lo;

    // External sources sit at even indices.
    for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
        irq_pin_src u_pin (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_pin_n[k]),
            .edge_mode (ext_edge_sel[k]),
            .clr       (take_src[2*k] | flag_clr[2*k]),
            .flag      (pend[2*k])
        );
    end

    // Timer sources sit at odd indices.
    for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
        irq_evt_src u_evt (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (tmr_ovf[k]),
            .clr   (take_src[2*k+1] | flag_clr[2*k+1]),
            .flag  (pend[2*k+1])
        );
    end

    // The serial flag is owned by the UART and is only observed here.
    assign pend[SER_IDX] = ser_rx | ser_tx;

    // Gate pending flags with the individual and global enables.
    assign req = pend & irq_src_en & {NUM_SRC{irq_glob_en}};

    irq_pick u_pick (
        .req    (req),
        .pri    (irq_pri),
        .valid  (sel_valid),
        .idx    (sel_idx),
        .lvl_hi (sel_hi)
    );

    // Raise a request only when the active levels allow it.
    always_comb begin
        irq_req = sel_valid & ~isv_hi & (~isv_lo | sel_hi);
        irq_vec = vec_of(sel_idx);
        take    = irq_ack & irq_req;
    end

    // One-hot clear for the latched flag of the accepted source.
    always_comb begin
        for (int s = 0; s < NUM_LATCH; s++) begin
            take_src[s] = take && (sel_idx == IDX_W'(s));
        end
    end

    irq_isv u_isv (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_hi (take & sel_hi),
        .set_lo (take & ~sel_hi),
        .ret    (irq_ret),
        .isv_hi (isv_hi),
        .isv_lo (isv_lo)
    );
endmodule

// File: rtl/vec_irq_chk.sv
// Assertion checker bound to vec_irq_ctrl.
module vec_irq_chk
    import vec_irq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               irq_glob_en,
    input logic               irq_req,
    input logic [VEC_W-1:0]   irq_vec,
    input logic               irq_ack,
    input logic               irq_ret,
    input logic               ser_rx,
    input logic               ser_tx,
    input logic [NUM_SRC-1:0] pend,
    input logic               isv_hi,
    input logic               isv_lo
);
    p_vec_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec[2:0] == 3'd3 && irq_vec <= 16'h0023));

    p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_glob_en |-> !irq_req);

    p_hi_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        isv_hi |-> !irq_req);

    p_ack_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> (isv_hi || isv_lo));

    p_ret_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && isv_hi && !(irq_ack && irq_req)) |=> !isv_hi);

    p_ret_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !isv_hi && isv_lo && !(irq_ack && irq_req)) |=> !isv_lo);

    p_ser_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pend[SER_IDX] == (ser_rx || ser_tx));
endmodule

bind vec_irq_ctrl vec_irq_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_glob_en (irq_glob_en),
    .irq_req     (irq_req),
    .irq_vec     (irq_vec),
    .irq_ack     (irq_ack),
    .irq_ret     (irq_ret),
    .ser_rx      (ser_rx),
    .ser_tx      (ser_tx),
    .pend        (pend),
    .isv_hi      (isv_hi),
    .isv_lo      (isv_lo)
);

// File: tb/vec_irq_ctrl_tb_top.sv
module vec_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_pin_n = 2'b11;
    logic [1:0]  ext_edge_sel = 2'b00;
    logic [1:0]  tmr_ovf = 2'b00;
    logic        ser_rx = 1'b0;
    logic        ser_tx = 1'b0;
    logic        irq_glob_en = 1'b0;
    logic [4:0]  irq_src_en = 5'd0;
    logic [4:0]  irq_pri = 5'd0;
    logic [3:0]  flag_clr = 4'd0;
    logic        irq_ack = 1'b0;
    logic        irq_ret = 1'b0;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic [4:0]  pend;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #4 clk = ~clk;

    vec_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .ext_edge_sel(ext_edge_sel),
        .tmr_ovf(tmr_ovf), .ser_rx(ser_rx), .ser_tx(ser_tx), .irq_glob_en(irq_glob_en),
        .irq_src_en(irq_src_en), .irq_pri(irq_pri), .flag_clr(flag_clr),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req), .irq_vec(irq_vec),
        .pend(pend)
    );

    task automatic tick(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic check_eq(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    endtask

    task automatic pulse_ret();
        irq_ret = 1'b1; tick(); irq_ret = 1'b0;
    endtask

    task automatic pulse_tmr(input logic [1:0] m);
        tmr_ovf = m; tick(); tmr_ovf = 2'b00;
    endtask

    // Expected winner: high level first, then the lowest index.
    function automatic int winner(input logic [4:0] r, input logic [4:0] p);
        logic [4:0] h;
        logic [4:0] pool;
        h = r & p;
        pool = (h != 0) ? h : r;
        for (int i = 0; i < 5; i++) if (pool[i]) return i;
        return 0;
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        summary();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        irq_glob_en = 1'b1; irq_src_en = 5'h1F;
        tick();
        // R12: reset state
        check_eq("R12 pend after reset", pend, 0);
        check_eq("R12 irq_req after reset", irq_req, 0);

        // R1 R4 R5: every pending pattern against every priority mask
        for (int p = 1; p < 32; p++) begin
            ext_pin_n = ~{p[2], p[0]};
            ser_rx = p[4];
            pulse_tmr({p[3], p[1]});
            tick(2);
            check_eq("R11 pend pattern", pend, p);
            for (int pr = 0; pr < 32; pr++) begin
                irq_pri = pr[4:0];
                #1;
                check_eq("R1 R4 R5 vector", irq_vec, 3 + 8 * winner(p[4:0], pr[4:0]));
                check_eq("R4 request", irq_req, 1);
            end
            // R3 R2: enable sweep on the same pattern
            irq_pri = 5'd0;
            for (int e = 0; e < 64; e++) begin
                irq_src_en = e[4:0]; irq_glob_en = e[5];
                #1;
                if (e[5] && (p[4:0] & e[4:0]) != 0) begin
                    check_eq("R3 enabled request", irq_req, 1);
                    check_eq("R3 vector", irq_vec, 3 + 8 * winner(p[4:0] & e[4:0], 5'd0));
                end else begin
                    check_eq("R2 R3 gated", irq_req, 0);
                end
            end
            irq_src_en = 5'h1F; irq_glob_en = 1'b1;
            ext_pin_n = 2'b11; ser_rx = 1'b0;
            flag_clr = 4'b1010; tick(); flag_clr = 4'd0;
            tick(2);
            check_eq("R8 cleanup", pend, 0);
        end

        // R8: edge-mode timing and hold
        ext_edge_sel = 2'b11; irq_src_en = 5'h01; irq_pri = 5'd0;
        tick();
        ext_pin_n[0] = 1'b0;
        tick();
        check_eq("R8 flag after one edge", pend[0], 0);
        tick();
        check_eq("R8 flag after two edges", pend[0], 1);
        ext_pin_n[0] = 1'b1;
        tick(2);
        check_eq("R8 flag held after pin rises", pend[0], 1);
        check_eq("R1 ext0 vector", irq_vec, 16'h0003);
        pulse_ack();
        check_eq("R10 ack clears edge flag", pend[0], 0);
        check_eq("R6 low level active, no request", irq_req, 0);

        // R6: low handler blocks low, admits high
        irq_src_en = 5'h0B;
        pulse_tmr(2'b01);
        check_eq("R6 low blocked by low", irq_req, 0);
        irq_pri = 5'b00010;
        #1;
        check_eq("R6 high preempts low", irq_req, 1);
        check_eq("R1 timer0 vector", irq_vec, 16'h000B);
        pulse_ack();
        check_eq("R10 ack clears timer flag", pend[1], 0);
        pulse_tmr(2'b10);
        irq_pri = 5'b01010;
        #1;
        check_eq("R6 high blocked by high", irq_req, 0);
        check_eq("R10 other flag untouched", pend[3], 1);

        // R7: return pulses leave highest level first
        pulse_ret();
        check_eq("R7 high left, high req admitted", irq_req, 1);
        check_eq("R1 timer1 vector", irq_vec, 16'h001B);
        irq_pri = 5'b00000;
        #1;
        check_eq("R7 low still active", irq_req, 0);
        pulse_ret();
        check_eq("R7 low left", irq_req, 1);
        pulse_ack();
        pulse_ret();
        check_eq("R10 timer1 cleared", pend, 0);

        // R11: serial flag follows rx|tx and survives ack
        irq_src_en = 5'h10; ser_tx = 1'b1;
        #1;
        check_eq("R11 tx pending", pend[4], 1);
        check_eq("R1 serial vector", irq_vec, 16'h0023);
        pulse_ack();
        check_eq("R11 serial kept after ack", pend[4], 1);
        pulse_ret();
        check_eq("R11 serial requests again", irq_req, 1);
        ser_tx = 1'b0; ser_rx = 1'b1;
        #1;
        check_eq("R11 rx pending", pend[4], 1);
        ser_rx = 1'b0;
        #1;
        check_eq("R11 serial idle", pend[4], 0);

        // R9: level mode follows the pin, not cleared by ack
        ext_edge_sel = 2'b00; irq_src_en = 5'h04;
        ext_pin_n[1] = 1'b0;
        tick();
        check_eq("R9 lag one edge", pend[2], 0);
        tick();
        check_eq("R9 level flag", pend[2], 1);
        check_eq("R1 ext1 vector", irq_vec, 16'h0013);
        pulse_ack();
        check_eq("R9 level flag after ack", pend[2], 1);
        pulse_ret();
        ext_pin_n[1] = 1'b1;
        tick(2);
        check_eq("R9 level flag released", pend[2], 0);

        // R13: ack with no request changes nothing
        irq_glob_en = 1'b0; irq_src_en = 5'h02;
        pulse_tmr(2'b01);
        check_eq("R2 no request when global off", irq_req, 0);
        pulse_ack();
        check_eq("R13 flag kept", pend[1], 1);
        irq_glob_en = 1'b1;
        #1;
        check_eq("R13 no level entered", irq_req, 1);
        pulse_ack();
        pulse_ret();

        // R8: software clear of an edge flag
        ext_edge_sel = 2'b01; irq_src_en = 5'h01;
        ext_pin_n[0] = 1'b0;
        tick(2);
        ext_pin_n[0] = 1'b1;
        check_eq("R8 edge flag set", pend[0], 1);
        flag_clr = 4'b0001; tick(); flag_clr = 4'd0;
        check_eq("R8 software clear", pend[0], 0);
        check_eq("R8 no request after clear", irq_req, 0);

        summary();
    end
endmodule